// File: doc/BRIEF.md
# OFDM Subcarrier Mapper with Pilot Insertion

This block assembles one 512-bin frequency-domain OFDM symbol from a stream of complex data symbols. Each symbol has 300 occupied positions: 250 data symbols and 50 pilots. In every run of six positions the first is a pilot and the next five are data. The 300 occupied positions form two halves of 150. The upper half goes just above DC. The lower half goes at the top of the bin range, where the negative frequencies sit. Every other bin carries exactly zero.

Data arrives on a valid/ready input. The mapped symbol leaves on a valid/ready output in natural bin order, 0 to 511, with a start marker on bin 0 and an end marker on bin 511. Bins 362 to 511 use the first 125 data symbols, but they leave last. The block therefore holds those 125 symbols in a local store before it emits bin 0. The second 125 data symbols pass straight through while bins 1 to 150 are emitted. Pilots come from a table computed at elaboration.

The sequencer is a state machine with five states:
- `ST_FILL` accepts the first 125 data symbols into the store and emits nothing.
- `ST_DC` emits bin 0.
- `ST_UPPER` emits bins 1 to 150: pilots from the table and data passed through from the input.
- `ST_GAP` emits the zero bins 151 to 361.
- `ST_LOWER` emits bins 362 to 511: pilots from the table and data read from the store.

Its transitions are:
- store full: `ST_FILL` to `ST_DC`
- DC sent: `ST_DC` to `ST_UPPER`
- upper done: `ST_UPPER` to `ST_GAP`, on the handshake of bin 150
- gap done: `ST_GAP` to `ST_LOWER`, on the handshake of bin 361
- symbol done: `ST_LOWER` to `ST_FILL`, on the handshake of bin 511

Top module: `subcarrier_mapper`

## Requirements
- R1: After reset the output is not valid and the input is ready.
- R2: The first 125 data symbols of each OFDM symbol are accepted with no output valid. Bin 0 is handed over only when exactly 125 symbols of that OFDM symbol have been accepted.
- R3: Bin 0 (DC) carries I = 0 and Q = 0 and is flagged by the start marker.
- R4: Bins 1 to 150, in order, carry interleaved positions 150 to 299.
- R5: Bins 362 to 511, in order, carry interleaved positions 0 to 149.
- R6: Interleaved position k is a pilot when k mod 6 equals 0. That pilot is pilot number k/6. Any other k carries data symbol number k - k/6 - 1, counting from 0 in arrival order.
- R7: Pilot p has I = -11585 when bit 2 of (37p + 11) is 1 and I = +11585 otherwise. It has Q = -11585 when bit 3 of (13p + 5) is 1 and Q = +11585 otherwise.
- R8: Bins 151 to 361 carry I = 0 and Q = 0.
- R9: The start marker is set on bin 0 only. The end marker is set on bin 511 only.
- R10: Input ready is low while zero bins, pilot bins or lower-half bins are being emitted. On an upper-half data bin, out_valid follows in_valid and in_ready follows out_ready.
- R11: While the output is valid and not taken, the start and end markers hold their values into the next cycle.
- R12: After the handshake of bin 511 the block returns to accepting data with the output not valid. Exactly 250 symbols have been consumed per OFDM symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data symbol offered |
| in_ready | output | 1 | Data symbol accepted this cycle when also valid |
| in_i | input | 16 | Data symbol in-phase, signed |
| in_q | input | 16 | Data symbol quadrature, signed |
| out_valid | output | 1 | Bin sample offered |
| out_ready | input | 1 | Downstream takes the bin sample |
| out_i | output | 16 | Bin in-phase, signed |
| out_q | output | 16 | Bin quadrature, signed |
| out_sos | output | 1 | Start of symbol (bin 0) |
| out_eos | output | 1 | End of symbol (bin 511) |

## Verification
In the upper half, two things can happen in one cycle: downstream back-pressure and upstream starvation can both hit the same pass-through data bin. The block must then neither drop nor repeat a data symbol, and the bin count must not advance. The bench drops out_ready and in_valid at random and independently, so both fall together on many upper data bins. The 512-bin stream is compared entry by entry against a queue built from the placement rule. The number of accepted inputs is also checked at bin 0 and at bin 511 of every symbol.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam int SAMPLE_W = 16;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } iq_t;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_DC,
        ST_UPPER,
        ST_GAP,
        ST_LOWER
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_PILOT,
        SRC_LIVE,
        SRC_HELD
    } src_sel_t;

    // Pilot p: sign of I from bit 2 of 37p+11, sign of Q from bit 3 of 13p+5
    function automatic iq_t pilot_value(input int unsigned idx,
                                        input logic signed [SAMPLE_W-1:0] amp);
        logic [31:0] hi;
        logic [31:0] hq;
        iq_t r;
        hi = 32'(idx * 37 + 11);
        hq = 32'(idx * 13 + 5);
        r.re = hi[2] ? -amp : amp;
        r.im = hq[3] ? -amp : amp;
        return r;
    endfunction

endpackage

// File: rtl/scm_pilot_table.sv
module scm_pilot_table
    import scm_pkg::*;
#(
    parameter int NPILOT = 50,
    parameter int PIL_W  = $clog2(NPILOT),
    parameter logic signed [SAMPLE_W-1:0] AMP = 16'sd11585
) (
    input  logic [PIL_W-1:0] idx,
    output iq_t              value
);

    iq_t table_q [NPILOT];

    for (genvar g = 0; g < NPILOT; g++) begin : g_entry
        assign table_q[g] = pilot_value(g, AMP);
    end

    always_comb begin
        if (int'(idx) < NPILOT) begin
            value = table_q[idx];
        end else begin
            value = '0;
        end
    end

endmodule

// File: rtl/scm_hold_buf.sv
module scm_hold_buf
    import scm_pkg::*;
#(
    parameter int DEPTH = 125,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  iq_t           wdata,
    input  logic [AW-1:0] raddr,
    output iq_t           rdata
);

    iq_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if (int'(raddr) < DEPTH) begin
            rdata = mem[raddr];
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/scm_seq.sv
module scm_seq
    import scm_pkg::*;
#(
    parameter int NFFT    = 512,
    parameter int NDATA   = 250,
    parameter int NPILOT  = 50,
    parameter int SPACING = 6,
    parameter int PIL_W   = $clog2(NPILOT),
    parameter int AD_W    = $clog2(NDATA / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output src_sel_t         sel,
    output logic [PIL_W-1:0] pilot_idx,
    output logic             buf_we,
    output logic [AD_W-1:0]  buf_waddr,
    output logic [AD_W-1:0]  buf_raddr,
    output logic             sos,
    output logic             eos
);

    localparam int NOCC        = NDATA + NPILOT;
    localparam int HALF        = NOCC / 2;
    localparam int HALF_DATA   = NDATA / 2;
    localparam int HALF_PILOT  = NPILOT / 2;
    localparam int LOWER_START = NFFT - HALF;
    localparam int BIN_W       = $clog2(NFFT);
    localparam int PH_W        = $clog2(SPACING);

    localparam logic [BIN_W-1:0] BIN_UP_LAST  = BIN_W'(HALF);
    localparam logic [BIN_W-1:0] BIN_GAP_LAST = BIN_W'(LOWER_START - 1);
    localparam logic [BIN_W-1:0] BIN_LAST     = BIN_W'(NFFT - 1);
    localparam logic [PH_W-1:0]  PH_LAST      = PH_W'(SPACING - 1);
    localparam logic [AD_W-1:0]  WR_LAST      = AD_W'(HALF_DATA - 1);

    seq_state_t       state_q, state_d;
    logic [BIN_W-1:0] bin_q;
    logic [PH_W-1:0]  phase_q;
    logic [PIL_W-1:0] pil_q;
    logic [AD_W-1:0]  wr_q;
    logic [AD_W-1:0]  rd_q;
    logic             fire;
    logic             take;
    logic             at_pilot;

    assign at_pilot  = (phase_q == '0);
    assign pilot_idx = pil_q;
    assign buf_waddr = wr_q;
    assign buf_raddr = rd_q;
    assign fire      = out_valid && out_ready;
    assign take      = in_valid && in_ready;

    // Output decode
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        sel       = SRC_ZERO;
        buf_we    = 1'b0;
        sos       = 1'b0;
        eos       = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                in_ready = 1'b1;
                buf_we   = in_valid;
            end
            ST_DC: begin
                out_valid = 1'b1;
                sos       = 1'b1;
            end
            ST_UPPER: begin
                if (at_pilot) begin
                    sel       = SRC_PILOT;
                    out_valid = 1'b1;
                end else begin
                    sel       = SRC_LIVE;
                    out_valid = in_valid;
                    in_ready  = out_ready;
                end
            end
            ST_GAP: begin
                out_valid = 1'b1;
            end
            ST_LOWER: begin
                sel       = at_pilot ? SRC_PILOT : SRC_HELD;
                out_valid = 1'b1;
                eos       = (bin_q == BIN_LAST);
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (take && wr_q == WR_LAST)         state_d = ST_DC;
            ST_DC:    if (fire)                            state_d = ST_UPPER;
            ST_UPPER: if (fire && bin_q == BIN_UP_LAST)    state_d = ST_GAP;
            ST_GAP:   if (fire && bin_q == BIN_GAP_LAST)   state_d = ST_LOWER;
            ST_LOWER: if (fire && bin_q == BIN_LAST)       state_d = ST_FILL;
            default:                                       state_d = ST_FILL;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            bin_q   <= '0;
            phase_q <= '0;
            pil_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_FILL: begin
                    if (take) begin
                        wr_q <= (wr_q == WR_LAST) ? '0 : wr_q + 1'b1;
                    end
                    bin_q <= '0;
                end
                ST_DC: begin
                    if (fire) begin
                        bin_q   <= BIN_W'(1);
                        phase_q <= '0;
                        pil_q   <= PIL_W'(HALF_PILOT);
                    end
                end
                ST_UPPER, ST_LOWER: begin
                    if (fire) begin
                        bin_q   <= bin_q + 1'b1;
                        phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                        if (at_pilot) begin
                            pil_q <= pil_q + 1'b1;
                        end else if (state_q == ST_LOWER) begin
                            rd_q <= rd_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (fire) begin
                        bin_q <= bin_q + 1'b1;
                        if (bin_q == BIN_GAP_LAST) begin
                            phase_q <= '0;
                            pil_q   <= '0;
                            rd_q    <= '0;
                        end
                    end
                end
                default: begin
                    bin_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/subcarrier_mapper.sv
module subcarrier_mapper
    import scm_pkg::*;
#(
    parameter int NFFT    = 512,
    parameter int NDATA   = 250,
    parameter int NPILOT  = 50,
    parameter int SPACING = 6,
    parameter logic signed [SAMPLE_W-1:0] PILOT_AMP = 16'sd11585
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q,
    output logic                out_sos,
    output logic                out_eos
);

    localparam int HALF_DATA = NDATA / 2;
    localparam int PIL_W     = $clog2(NPILOT);
    localparam int AD_W      = $clog2(HALF_DATA);

    src_sel_t         sel;
    logic [PIL_W-1:0] pilot_idx;
    logic             buf_we;
    logic [AD_W-1:0]  buf_waddr;
    logic [AD_W-1:0]  buf_raddr;
    iq_t              live_iq;
    iq_t              held_iq;
    iq_t              pilot_iq;
    iq_t              mux_iq;

    assign live_iq.re = in_i;
    assign live_iq.im = in_q;

    scm_seq #(
        .NFFT    (NFFT),
        .NDATA   (NDATA),
        .NPILOT  (NPILOT),
        .SPACING (SPACING),
        .PIL_W   (PIL_W),
        .AD_W    (AD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .sel       (sel),
        .pilot_idx (pilot_idx),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_raddr (buf_raddr),
        .sos       (out_sos),
        .eos       (out_eos)
    );

    scm_hold_buf #(
        .DEPTH (HALF_DATA),
        .AW    (AD_W)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (live_iq),
        .raddr (buf_raddr),
        .rdata (held_iq)
    );

    scm_pilot_table #(
        .NPILOT (NPILOT),
        .PIL_W  (PIL_W),
        .AMP    (PILOT_AMP)
    ) u_pilots (
        .idx   (pilot_idx),
        .value (pilot_iq)
    );

    always_comb begin
        unique case (sel)
            SRC_PILOT: mux_iq = pilot_iq;
            SRC_LIVE:  mux_iq = live_iq;
            SRC_HELD:  mux_iq = held_iq;
            default:   mux_iq = '0;
        endcase
    end

    assign out_i = mux_iq.re;
    assign out_q = mux_iq.im;

endmodule

// File: rtl/scm_checker.sv
module scm_checker #(
    parameter int NFFT = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_i,
    input logic [15:0] out_q,
    input logic        out_sos,
    input logic        out_eos
);

    localparam int BIN_W = $clog2(NFFT);
    localparam logic [BIN_W-1:0] LAST = BIN_W'(NFFT - 1);

    logic [BIN_W-1:0] beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (out_valid && out_ready) begin
            beat <= (beat == LAST) ? '0 : beat + 1'b1;
        end
    end

    p_dc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sos |-> out_i == 16'd0 && out_q == 16'd0);

    p_sos_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sos |-> beat == '0);

    p_eos_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eos |-> beat == LAST);

    p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && out_valid |-> out_ready);

    p_markers_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_sos) && $stable(out_eos));

    p_back_to_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eos |=> !out_valid && in_ready);

    p_no_input_at_dc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> !in_ready);

endmodule

bind subcarrier_mapper scm_checker #(.NFFT(NFFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_sos   (out_sos),
    .out_eos   (out_eos)
);

// File: tb/subcarrier_mapper_tb.sv
module subcarrier_mapper_tb;

    localparam int NFFT  = 512;
    localparam int NDATA = 250;
    localparam int HALF  = 150;
    localparam int LSTRT = NFFT - HALF;
    localparam int HDATA = NDATA / 2;
    localparam logic signed [15:0] AMP = 16'sd11585;
    localparam int LIMIT = 150000;

    localparam int K_ZERO  = 0;
    localparam int K_PILOT = 1;
    localparam int K_UDATA = 2;
    localparam int K_LDATA = 3;

    typedef struct {
        logic [15:0] i;
        logic [15:0] q;
        bit          sos;
        bit          eos;
        int          kind;
        int          bin;
        int          sym;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic        out_sos;
    logic        out_eos;

    exp_t        exp_q[$];
    logic [31:0] din_q[$];
    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int accepted = 0;
    bit stall = 1'b0;
    int sym_cnt = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    subcarrier_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_sos   (out_sos),
        .out_eos   (out_eos)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // R7 pilot rule, written from the requirement
    function automatic logic [31:0] pilot_ref(input int p);
        logic [31:0] a;
        logic [31:0] b;
        logic signed [15:0] pi;
        logic signed [15:0] pq;
        a  = 32'(37 * p + 11);
        b  = 32'(13 * p + 5);
        pi = a[2] ? -AMP : AMP;
        pq = b[3] ? -AMP : AMP;
        return {pi, pq};
    endfunction

    // Driver: push one OFDM symbol of data and its expected 512 bins (R4 R5 R6 R8)
    task automatic push_symbol(input int seed);
        logic [31:0] dat [NDATA];
        for (int d = 0; d < NDATA; d++) begin
            dat[d] = {16'(seed * 997 + d * 131 + 1), 16'(seed * 7 - d * 53)};
            din_q.push_back(dat[d]);
        end
        for (int b = 0; b < NFFT; b++) begin
            exp_t e;
            int k;
            e.bin = b;
            e.sym = sym_cnt;
            e.sos = (b == 0);
            e.eos = (b == NFFT - 1);
            e.i = '0;
            e.q = '0;
            e.kind = K_ZERO;
            k = -1;
            if (b >= 1 && b <= HALF) k = b - 1 + HALF;
            else if (b >= LSTRT) k = b - LSTRT;
            if (k >= 0) begin
                if (k % 6 == 0) begin
                    e.kind = K_PILOT;
                    {e.i, e.q} = pilot_ref(k / 6);
                end else begin
                    e.kind = (b <= HALF) ? K_UDATA : K_LDATA;
                    {e.i, e.q} = dat[k - k / 6 - 1];
                end
            end
            exp_q.push_back(e);
        end
        sym_cnt++;
    endtask

    // Producer
    initial begin
        bit took;
        @(posedge rst_n);
        forever begin
            if (din_q.size() == 0 || (stall && ($urandom % 4 == 0))) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                {in_i, in_q} = din_q[0];
            end
            @(negedge clk);
            took = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (took) void'(din_q.pop_front());
        end
    end

    // Consumer
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12", "output with nothing expected", {16'h0, out_i}, 32'h0);
                    end else begin
                        exp_t e;
                        e = exp_q[0];
                        if (e.kind == K_UDATA) begin
                            check(in_ready == out_ready, "R10", "ready follows out_ready on upper data",
                                  32'(in_ready), 32'(out_ready));
                        end else begin
                            check(in_ready == 1'b0, "R10", "input ready on non-live bin",
                                  32'(in_ready), 32'h0);
                        end
                        if (out_ready) begin
                            string req;
                            req = (e.kind == K_PILOT) ? "R7" :
                                  (e.kind == K_UDATA) ? "R4" :
                                  (e.kind == K_LDATA) ? "R5" :
                                  (e.bin == 0) ? "R3" : "R8";
                            check({out_i, out_q} == {e.i, e.q}, req,
                                  $sformatf("bin %0d sample", e.bin), {out_i, out_q}, {e.i, e.q});
                            check(out_sos == e.sos && out_eos == e.eos, "R9",
                                  $sformatf("bin %0d markers", e.bin),
                                  {30'h0, out_sos, out_eos}, {30'h0, e.sos, e.eos});
                            if (e.bin == 0) begin
                                check(accepted == e.sym * NDATA + HDATA, "R2", "inputs taken before DC",
                                      32'(accepted), 32'(e.sym * NDATA + HDATA));
                            end
                            if (e.bin == NFFT - 1) begin
                                check(accepted == (e.sym + 1) * NDATA, "R12", "inputs taken by last bin",
                                      32'(accepted), 32'((e.sym + 1) * NDATA));
                            end
                            void'(exp_q.pop_front());
                        end
                    end
                end
                if (in_valid && in_ready) accepted++;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);

        // Plain streaming, no stalls (R6 ordering)
        push_symbol(1);
        while ((exp_q.size() != 0) && cyc < LIMIT) @(posedge clk);

        // Random back-pressure and starvation, two symbols back to back (R11 R12)
        stall = 1'b1;
        push_symbol(2);
        push_symbol(3);
        while ((exp_q.size() != 0) && cyc < LIMIT) @(posedge clk);
        stall = 1'b0;

        push_symbol(4);
        while ((exp_q.size() != 0) && cyc < LIMIT) @(posedge clk);

        if (exp_q.size() != 0) begin
            check(1'b0, "R12", "watchdog expired, bins outstanding",
                  32'(exp_q.size()), 32'h0);
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R12", "idle in fill after last symbol",
              {30'h0, out_valid, in_ready}, 32'h1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule